// File: doc/BRIEF.md
# Byte Field Load/Deposit Unit

This unit pulls a bit field out of a 36-bit word, or writes a new value into that field. A field is given by a position P and a size S. P is the index of the field's least significant bit, with bits numbered from 0 at the LSB. S is the width in bits. A load returns the field right-justified, with zeros above it. A deposit writes the low S bits of a data word into the field and keeps every other bit of the memory word.

The field can be given in one of two ways: as explicit P and S values, or as a compact 6-bit global code that selects one of a fixed set of size/position pairs. Positions and sizes above 36 are clamped to 36. A field that runs past bit 35 is cut off at the top of the word. The deposit is built as a chain of three funnel shifts over a 72-bit pair.

Requests are accepted on every cycle. Each result appears, registered, exactly one cycle after its request, together with a flag that marks an illegal global code.

Top module: `byte_field_unit`

## Requirements
- R1: With `req_op`=0 (load), `rsp_word` holds the word's bits P..P+S-1 at bits 0..S-1, and every higher bit of `rsp_word` is zero.
- R2: With `req_op`=1 (deposit), bits P..P+S-1 of `rsp_word` hold bits 0..S-1 of `req_data`, and every other bit equals `req_word`.
- R3: A position or size above 36 is treated as 36. A field whose position is 36 selects no bits: a load returns zero and a deposit returns the word unchanged.
- R4: When P+S exceeds 36, only bits P..35 take part in the load or deposit.
- R5: A size of zero makes a load return zero and makes a deposit return the word unchanged.
- R6: With `req_global`=1, codes 45 to 53 octal select size 6 with P = 36, 30, 24, 18, 12, 6, 0 in rising code order. `req_pos` and `req_size` are ignored.
- R7: Global codes 54 to 60 octal select size 8 with P = 36, 28, 20, 12, 4. Codes 61 to 66 octal select size 7 with P = 36, 29, 22, 15, 8, 1.
- R8: Global codes 67 to 73 octal select size 9 with P = 36, 27, 18, 9, 0. Codes 74 to 76 octal select size 18 with P = 36, 18, 0.
- R9: With `req_global`=1, code 77 octal or any code below 45 octal sets `rsp_illegal`, and `rsp_word` equals `req_word`. With `req_global`=0, `req_code` has no effect.
- R10: `req_ready` is always high. Reset clears `rsp_valid`, `rsp_word` and `rsp_illegal`. `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, so back-to-back requests give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always high; a request is taken every cycle |
| req_op | input | 1 | 0 load, 1 deposit |
| req_global | input | 1 | 1 selects the field through `req_code` |
| req_code | input | 6 | Compact global size/position code |
| req_pos | input | 6 | Field position P when not global |
| req_size | input | 6 | Field size S when not global |
| req_word | input | 36 | Memory word |
| req_data | input | 36 | Value whose low bits are deposited |
| rsp_valid | output | 1 | Result present |
| rsp_word | output | 36 | Loaded field or updated word |
| rsp_illegal | output | 1 | Illegal global code seen |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- that an illegal code passes the word through unchanged;
- that a load result has no bits set above the clamped size;
- that a deposit touches no bit outside the clamped field;
- that the clamped field always fits in the word;
- that the code decoder only ever produces one of the five legal sizes.

Only the bench's scenarios can show some things. These are the exact decoded position for each code, the correct placement of the deposited bits inside the field, and the behaviour at the boundaries: truncation at bit 35, position 36, clamping of oversized values, and zero size. The bench shows them by comparing every result against an independent bit-by-bit model.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic {
    BFU_LOAD    = 1'b0,
    BFU_DEPOSIT = 1'b1
  } bfu_op_e;

  // Code ranges of the compact global field codes (octal).
  localparam logic [5:0] GC_S6_LO  = 6'o45;
  localparam logic [5:0] GC_S6_HI  = 6'o53;
  localparam logic [5:0] GC_S8_LO  = 6'o54;
  localparam logic [5:0] GC_S8_HI  = 6'o60;
  localparam logic [5:0] GC_S7_LO  = 6'o61;
  localparam logic [5:0] GC_S7_HI  = 6'o66;
  localparam logic [5:0] GC_S9_LO  = 6'o67;
  localparam logic [5:0] GC_S9_HI  = 6'o73;
  localparam logic [5:0] GC_S18_LO = 6'o74;
  localparam logic [5:0] GC_S18_HI = 6'o76;
endpackage

// File: rtl/bfu_code_decode.sv
module bfu_code_decode
  import bfu_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int CODE_W = 6,
  parameter int POS_W  = $clog2(WORD_W + 1)
) (
  input  logic [CODE_W-1:0] code,
  output logic [POS_W-1:0]  pos,
  output logic [POS_W-1:0]  size,
  output logic              illegal
);
  // Position for entry idx of a group: starts at the word top, steps down by size.
  function automatic logic [POS_W-1:0] grp_pos(input int step, input int idx);
    return POS_W'(WORD_W - step * idx);
  endfunction

  int c;
  always_comb begin
    c       = int'(code);
    pos     = '0;
    size    = '0;
    illegal = 1'b0;
    if (c >= int'(GC_S6_LO) && c <= int'(GC_S6_HI)) begin
      size = POS_W'(6);
      pos  = grp_pos(6, c - int'(GC_S6_LO));
    end else if (c >= int'(GC_S8_LO) && c <= int'(GC_S8_HI)) begin
      size = POS_W'(8);
      pos  = grp_pos(8, c - int'(GC_S8_LO));
    end else if (c >= int'(GC_S7_LO) && c <= int'(GC_S7_HI)) begin
      size = POS_W'(7);
      pos  = grp_pos(7, c - int'(GC_S7_LO));
    end else if (c >= int'(GC_S9_LO) && c <= int'(GC_S9_HI)) begin
      size = POS_W'(9);
      pos  = grp_pos(9, c - int'(GC_S9_LO));
    end else if (c >= int'(GC_S18_LO) && c <= int'(GC_S18_HI)) begin
      size = POS_W'(18);
      pos  = grp_pos(18, c - int'(GC_S18_LO));
    end else begin
      illegal = 1'b1;
    end
  end
endmodule

// File: rtl/bfu_field_clamp.sv
module bfu_field_clamp #(
  parameter int WORD_W = 36,
  parameter int POS_W  = $clog2(WORD_W + 1)
) (
  input  logic [POS_W-1:0] pos_in,
  input  logic [POS_W-1:0] size_in,
  output logic [POS_W-1:0] pos_eff,
  output logic [POS_W-1:0] size_eff
);
  localparam logic [POS_W-1:0] TOP = POS_W'(WORD_W);

  logic [POS_W-1:0] size_c;
  logic [POS_W-1:0] room;

  always_comb begin
    pos_eff  = (pos_in > TOP) ? TOP : pos_in;
    size_c   = (size_in > TOP) ? TOP : size_in;
    room     = TOP - pos_eff;
    size_eff = (size_c > room) ? room : size_c;
  end
endmodule

// File: rtl/bfu_funnel.sv
module bfu_funnel #(
  parameter int WORD_W = 36,
  parameter int AMT_W  = $clog2(WORD_W + 1) + 1
) (
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  input  logic [AMT_W-1:0]  amt,
  output logic [WORD_W-1:0] out
);
  logic [2*WORD_W-1:0] pair;
  always_comb begin
    pair = {hi, lo} << amt;
    out  = pair[2*WORD_W-1:WORD_W];
  end
endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int POS_W  = $clog2(WORD_W + 1)
) (
  input  logic              op,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] data,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  size,
  output logic [WORD_W-1:0] result
);
  localparam int AMT_W = POS_W + 1;
  localparam logic [AMT_W-1:0] FULL = AMT_W'(WORD_W);

  logic [AMT_W-1:0]  amt1, amt2, amt3;
  logic [WORD_W-1:0] rot_down;   // field moved down to bit 0
  logic [WORD_W-1:0] merged;     // new byte on top, remaining word below
  logic [WORD_W-1:0] dep_word;
  logic [WORD_W-1:0] low_mask;

  assign amt1 = FULL - AMT_W'(pos);
  assign amt2 = FULL - AMT_W'(size);
  assign amt3 = AMT_W'(pos) + AMT_W'(size);

  // Shift 1: rotate the word so bit P lands on bit 0.
  bfu_funnel #(.WORD_W(WORD_W), .AMT_W(AMT_W)) u_sh1 (
    .hi(word), .lo(word), .amt(amt1), .out(rot_down));
  // Shift 2: drop the old field, bring in the new byte at the top.
  bfu_funnel #(.WORD_W(WORD_W), .AMT_W(AMT_W)) u_sh2 (
    .hi(data), .lo(rot_down), .amt(amt2), .out(merged));
  // Shift 3: rotate everything back into place.
  bfu_funnel #(.WORD_W(WORD_W), .AMT_W(AMT_W)) u_sh3 (
    .hi(merged), .lo(merged), .amt(amt3), .out(dep_word));

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_mask
      assign low_mask[i] = (AMT_W'(i) < AMT_W'(size));
    end
  endgenerate

  assign result = (bfu_op_e'(op) == BFU_LOAD) ? (rot_down & low_mask) : dep_word;
endmodule

// File: rtl/byte_field_unit.sv
module byte_field_unit
  import bfu_pkg::*;
#(
  parameter int WORD_W = 36,
  parameter int CODE_W = 6,
  parameter int POS_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic              req_global,
  input  logic [CODE_W-1:0] req_code,
  input  logic [POS_W-1:0]  req_pos,
  input  logic [POS_W-1:0]  req_size,
  input  logic [WORD_W-1:0] req_word,
  input  logic [WORD_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_word,
  output logic              rsp_illegal
);
  logic [POS_W-1:0]  dec_pos, dec_size, sel_pos, sel_size, pos_eff, size_eff;
  logic              dec_illegal, bad_code;
  logic [WORD_W-1:0] dp_result, fmask;

  assign req_ready = 1'b1;

  bfu_code_decode #(.WORD_W(WORD_W), .CODE_W(CODE_W), .POS_W(POS_W)) u_dec (
    .code(req_code), .pos(dec_pos), .size(dec_size), .illegal(dec_illegal));

  assign sel_pos  = req_global ? dec_pos  : req_pos;
  assign sel_size = req_global ? dec_size : req_size;
  assign bad_code = req_global & dec_illegal;

  bfu_field_clamp #(.WORD_W(WORD_W), .POS_W(POS_W)) u_clamp (
    .pos_in(sel_pos), .size_in(sel_size), .pos_eff(pos_eff), .size_eff(size_eff));

  bfu_datapath #(.WORD_W(WORD_W), .POS_W(POS_W)) u_dp (
    .op(req_op), .word(req_word), .data(req_data),
    .pos(pos_eff), .size(size_eff), .result(dp_result));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_word    <= '0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_word    <= bad_code ? req_word : dp_result;
        rsp_illegal <= bad_code;
      end
    end
  end

  // Field mask from the clamped values, for checking only.
  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_fmask
      assign fmask[i] = ((POS_W+1)'(i) >= (POS_W+1)'(pos_eff)) &&
                        ((POS_W+1)'(i) <  (POS_W+1)'(pos_eff) + (POS_W+1)'(size_eff));
    end
  endgenerate

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R10
  AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R10
  AST_ILLEGAL_WORD_KEPT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_illegal || rsp_word == $past(req_word))); // R9
  AST_LOAD_NARROW: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !bad_code && req_op == BFU_LOAD) |=>
      ((rsp_word >> $past(size_eff)) == '0)); // R1
  AST_DEPOSIT_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !bad_code && req_op == BFU_DEPOSIT) |=>
      (((rsp_word ^ $past(req_word)) & ~$past(fmask)) == '0)); // R2
  AST_FIELD_FITS: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ((POS_W+1)'(pos_eff) + (POS_W+1)'(size_eff) <= (POS_W+1)'(WORD_W))); // R4
  AST_DECODE_SIZE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_global && !dec_illegal) |->
      (dec_size == POS_W'(6) || dec_size == POS_W'(7) || dec_size == POS_W'(8) ||
       dec_size == POS_W'(9) || dec_size == POS_W'(18))); // R6
endmodule

// File: tb/tb_byte_field_unit.sv
module tb_byte_field_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_op = 1'b0, req_global = 1'b0;
  logic [5:0]  req_code = '0, req_pos = '0, req_size = '0;
  logic [35:0] req_word = '0, req_data = '0;
  logic        req_ready, rsp_valid, rsp_illegal;
  logic [35:0] rsp_word;

  int n_chk = 0, n_bad = 0;
  logic        pend = 1'b0;
  logic [35:0] exp_word;
  logic        exp_ill;
  string       exp_tag;

  always #10 clk = ~clk;

  byte_field_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_global(req_global), .req_code(req_code),
    .req_pos(req_pos), .req_size(req_size), .req_word(req_word),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
    .rsp_illegal(rsp_illegal));

  // Behavioural reference: decode, clamp, then walk the bits one at a time.
  function automatic void model(input bit op, input bit glob, input int code,
                                input int pos, input int size,
                                input logic [35:0] w, input logic [35:0] d,
                                output logic [35:0] r, output bit ill);
    int p, s;
    ill = 1'b0; r = w; p = pos; s = size;
    if (glob) begin
      if      (code >= 37 && code <= 43) begin s = 6;  p = 36 - 6  * (code - 37); end
      else if (code >= 44 && code <= 48) begin s = 8;  p = 36 - 8  * (code - 44); end
      else if (code >= 49 && code <= 54) begin s = 7;  p = 36 - 7  * (code - 49); end
      else if (code >= 55 && code <= 59) begin s = 9;  p = 36 - 9  * (code - 55); end
      else if (code >= 60 && code <= 62) begin s = 18; p = 36 - 18 * (code - 60); end
      else ill = 1'b1;
    end
    if (ill) return;
    if (p > 36) p = 36;
    if (s > 36) s = 36;
    if (!op) r = '0;
    for (int i = 0; i < 36; i++)
      if (i >= p && i < p + s) begin
        if (!op) r[i-p] = w[i];
        else     r[i]   = d[i-p];
      end
  endfunction

  task automatic check_pending();
    n_chk++;
    if (pend) begin
      if (!rsp_valid || rsp_word !== exp_word || rsp_illegal !== exp_ill) begin
        n_bad++;
        $display("FAIL %s: valid=%0b word=%o ill=%0b, expected valid=1 word=%o ill=%0b",
                 exp_tag, rsp_valid, rsp_word, rsp_illegal, exp_word, exp_ill);
      end
    end else if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R10: valid=%0b expected 0 with no request", rsp_valid);
    end
  endtask

  // Drive one request at a falling edge, then check it at the next falling edge.
  task automatic apply(input bit op, input bit glob, input int code, input int pos,
                       input int size, input logic [35:0] w, input logic [35:0] d,
                       input string tag);
    req_valid = 1'b1; req_op = op; req_global = glob;
    req_code = 6'(code); req_pos = 6'(pos); req_size = 6'(size);
    req_word = w; req_data = d;
    model(op, glob, code, pos, size, w, d, exp_word, exp_ill);
    exp_tag = tag; pend = 1'b1;
    @(negedge clk);
    check_pending();
  endtask

  task automatic idle();
    req_valid = 1'b0; pend = 1'b0;
    @(negedge clk);
    check_pending();
  endtask

  function automatic logic [35:0] rnd36();
    return {4'(($urandom)), 32'($urandom)};
  endfunction

  localparam logic [35:0] PAT = 36'o123456701234;
  localparam logic [35:0] DAT = 36'o765432107654;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_word !== '0 || rsp_illegal !== 1'b0 || req_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R10: reset valid=%0b word=%o ill=%0b ready=%0b, expected 0 0 0 1",
               rsp_valid, rsp_word, rsp_illegal, req_ready);
    end
    // R1 loads
    apply(0, 0, 0, 0, 36, PAT, DAT, "R1 full word");
    apply(0, 0, 0, 12, 6, PAT, DAT, "R1 mid field");
    apply(0, 0, 63, 30, 6, PAT, DAT, "R1 top field, code ignored (R9)");
    // R2 deposits
    apply(1, 0, 0, 6, 12, PAT, DAT, "R2 mid field");
    apply(1, 0, 0, 0, 36, PAT, DAT, "R2 full word");
    apply(1, 0, 5, 35, 1, PAT, DAT, "R2 top bit");
    // R3 position 36 and clamping
    apply(0, 0, 0, 36, 10, PAT, DAT, "R3 load P=36");
    apply(1, 0, 0, 36, 10, PAT, DAT, "R3 deposit P=36");
    apply(0, 0, 0, 50, 5, PAT, DAT, "R3 load P>36");
    apply(1, 0, 0, 63, 63, PAT, DAT, "R3 deposit P>36");
    apply(0, 0, 0, 0, 63, PAT, DAT, "R3 load S>36");
    apply(1, 0, 0, 0, 50, PAT, DAT, "R3 deposit S>36");
    // R4 truncation
    apply(0, 0, 0, 30, 12, PAT, DAT, "R4 load truncated");
    apply(1, 0, 0, 30, 12, PAT, DAT, "R4 deposit truncated");
    apply(1, 0, 0, 20, 40, PAT, DAT, "R4 deposit S>36 truncated");
    // R5 zero size
    apply(0, 0, 0, 7, 0, PAT, DAT, "R5 load S=0");
    apply(1, 0, 0, 7, 0, PAT, DAT, "R5 deposit S=0");
    idle();
    // R6..R8 every legal global code, both operations; pos/size inputs ignored
    for (int c = 37; c <= 62; c++) begin
      apply(0, 1, c, 3, 3, rnd36(), rnd36(), (c <= 43) ? "R6 global load" :
            (c <= 54) ? "R7 global load" : "R8 global load");
      apply(1, 1, c, 17, 2, rnd36(), rnd36(), (c <= 43) ? "R6 global deposit" :
            (c <= 54) ? "R7 global deposit" : "R8 global deposit");
    end
    // R9 illegal codes
    apply(0, 1, 63, 0, 36, PAT, DAT, "R9 code 77 load");
    apply(1, 1, 63, 0, 36, PAT, DAT, "R9 code 77 deposit");
    apply(1, 1, 0, 0, 36, PAT, DAT, "R9 code 0");
    apply(0, 1, 36, 0, 36, PAT, DAT, "R9 code 44");
    idle();
    idle();
    // R10 back-to-back plus random mix (R1/R2)
    for (int k = 0; k < 3000; k++) begin
      bit op = 1'($urandom);
      bit gl = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) idle();
      apply(op, gl, int'($urandom % 64), int'($urandom % 64), int'($urandom % 40),
            rnd36(), rnd36(), op ? "R2 random" : "R1 random");
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10: watchdog expired, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule